// File: doc/BRIEF.md
# SPI Card ID EEPROM Read Responder

This block is an SPI target that answers fixed four-byte read frames from a host SPI controller by returning bytes held in the identification EEPROM of one of two plug-in cards. An 8-bit card-select value, set elsewhere on the chip, decides at the start of each frame which card is addressed, if any. The second byte of the frame carries a byte offset. The block fetches the bytes at that offset and at the next offset through a synchronous read port to the selected card's storage. It then shifts them out as the last two bytes of the reply.

The SPI pins are treated as asynchronous inputs. They are brought into the system clock domain through a short synchronizer, and SCK edges are detected from the synchronized copy. The block therefore needs a system clock several times faster than SCK. When no card is selected, or the selected card reports no EEPROM, the whole reply is all ones and no storage read is made. This matches what an idle, pulled-up data line would show.

Top module: `spi_card_resp`

## Requirements
- R1: SPI mode 0 with MSB-first bytes: MOSI is taken on each rising SCK edge, and MISO changes only after a falling SCK edge (or at frame start). The first reply bit is valid before the first rising edge. SCK high and low phases must each last at least 6 system clocks.
- R2: While `spi_cs_n` is high, and after reset, `spi_miso` is driven to 1.
- R3: A frame is 32 SCK cycles with chip select low. The block takes frame byte 1 (the second byte, counting from 0) as the offset. The value of byte 0 (nominally 0x03) is ignored, and bytes 2 and 3 from the host are not used.
- R4: At the first cycle of a frame, the block samples `card_sel`. If bit 5 is 1, card 0 is addressed. Otherwise, if bit 3 is 1, card 1 is addressed. Bit 5 wins when both are 1. A change of `card_sel` later in the frame has no effect on that frame.
- R5: If neither select bit is 1, or the addressed card's present input is 0, the reply is 0xFF,0xFF,0xFF,0xFF. No read is issued to either card. There is no fallback to the other card.
- R6: For an addressed card that is present, the reply bytes in order are 0x00, 0x00, EEPROM[offset], EEPROM[offset+1].
- R7: The EEPROM address is the offset modulo 128 (offset bit 7 ignored). The second address is (offset+1) modulo 128, so offset 0x7F is followed by 0x00.
- R8: Per valid frame exactly two reads are issued, on consecutive cycles and only to the addressed card. They start after the offset byte is complete, and the data are captured before the first bit of reply byte 2 is driven.
- R9: Raising `spi_cs_n` mid-frame aborts the frame. The next frame starts again from byte 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data, 1 when idle |
| card_sel | input | 8 | Card-select value; bit 5 picks card 0, bit 3 picks card 1 |
| card0_present | input | 1 | Card 0 EEPROM present |
| card1_present | input | 1 | Card 1 EEPROM present |
| card0_rd_en | output | 1 | Read strobe to card 0 storage |
| card0_rd_addr | output | 7 | Read address to card 0 storage |
| card0_rd_data | input | 8 | Card 0 read data, valid the cycle after the strobe |
| card1_rd_en | output | 1 | Read strobe to card 1 storage |
| card1_rd_addr | output | 7 | Read address to card 1 storage |
| card1_rd_data | input | 8 | Card 1 read data, valid the cycle after the strobe |

## Verification
The bench sets both select bits together to check that card 0 wins. It also selects a card that is absent while the other card is present; a design that falls back to the other card would return its data instead of all ones. It reads offsets 0x7F and 0xC3 to catch a design that carries the address into bit 7 or does not wrap the second read to 0x00. It aborts a frame after 12 bits and then runs a full frame, which exposes a byte counter that survives chip-select release. It also changes `card_sel` mid-frame and uses a non-read opcode; a design that looks at the select value late, or decodes the opcode, would return a different reply.

// File: rtl/spi_card_resp_pkg.sv
package spi_card_resp_pkg;

  // Source of the reply data for the current frame.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CARD0 = 2'd1,
    SRC_CARD1 = 2'd2
  } src_e;

  // Storage fetch sequencer states.
  typedef enum logic [1:0] {
    FETCH_IDLE = 2'd0,
    FETCH_LO   = 2'd1,
    FETCH_HI   = 2'd2,
    FETCH_CAP  = 2'd3
  } fetch_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam logic [7:0] PAD_BYTE   = 8'h00;

  // Card 0 request wins over card 1; an absent card gives no data source.
  function automatic src_e pick_src(input logic want0, input logic want1,
                                    input logic have0, input logic have1);
    src_e r;
    if (want0)      r = have0 ? SRC_CARD0 : SRC_NONE;
    else if (want1) r = have1 ? SRC_CARD1 : SRC_NONE;
    else            r = SRC_NONE;
    return r;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for a small bus of asynchronous inputs.
module spi_pin_sync #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RESET_VAL}};
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_seq.sv
// Bit and byte position tracking and receive shifting within one frame.
module spi_frame_seq #(
  parameter int FRAME_BYTES = 4,
  parameter int OFFSET_BYTE = 1,
  localparam int IDX_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sck_rise,
  input  logic             mosi_bit,
  output logic [2:0]       bit_idx,
  output logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       rx_byte,
  output logic             offset_stb
);

  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(FRAME_BYTES);
  localparam logic [IDX_W-1:0] OFF_IDX = IDX_W'(OFFSET_BYTE);

  logic [2:0]       bit_q,  bit_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [7:0]       sh_q,   sh_d;
  logic             stb_q,  stb_d;

  always_comb begin
    bit_d  = bit_q;
    byte_d = byte_q;
    sh_d   = sh_q;
    stb_d  = 1'b0;
    if (!cs_act) begin
      bit_d  = '0;
      byte_d = '0;
    end else if (sck_rise && (byte_q < END_IDX)) begin
      sh_d  = {sh_q[6:0], mosi_bit};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        byte_d = byte_q + IDX_W'(1);
        stb_d  = (byte_q == OFF_IDX);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      stb_q  <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      byte_q <= byte_d;
      sh_q   <= sh_d;
      stb_q  <= stb_d;
    end
  end

  assign bit_idx    = bit_q;
  assign byte_idx   = byte_q;
  assign rx_byte    = sh_q;
  assign offset_stb = stb_q;

endmodule

// File: rtl/spi_card_fetch.sv
// Issues the two consecutive storage reads and captures their data.
module spi_card_fetch
  import spi_card_resp_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int N_CARDS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  src_e                           src,
  input  logic [ADDR_W-1:0]              base,
  output logic [N_CARDS-1:0]             rd_en,
  output logic [N_CARDS-1:0][ADDR_W-1:0] rd_addr,
  input  logic [N_CARDS-1:0][7:0]        rd_data,
  output logic [7:0]                     byte_lo,
  output logic [7:0]                     byte_hi
);

  fetch_e            state_q, state_d;
  logic [ADDR_W-1:0] base_q,  base_d;
  logic              card_q,  card_d;
  logic [7:0]        lo_q,    lo_d;
  logic [7:0]        hi_q,    hi_d;
  logic              issue;
  logic [ADDR_W-1:0] cur_addr;

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    card_d  = card_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    unique case (state_q)
      FETCH_IDLE: begin
        if (start && (src != SRC_NONE)) begin
          state_d = FETCH_LO;
          base_d  = base;
          card_d  = (src == SRC_CARD1);
        end
      end
      FETCH_LO: state_d = FETCH_HI;
      FETCH_HI: begin
        state_d = FETCH_CAP;
        lo_d    = rd_data[card_q];
      end
      FETCH_CAP: begin
        state_d = FETCH_IDLE;
        hi_d    = rd_data[card_q];
      end
      default: state_d = FETCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FETCH_IDLE;
      base_q  <= '0;
      card_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      card_q  <= card_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign issue    = (state_q == FETCH_LO) || (state_q == FETCH_HI);
  assign cur_addr = (state_q == FETCH_HI) ? (base_q + ADDR_W'(1)) : base_q;

  for (genvar c = 0; c < N_CARDS; c++) begin : g_port
    assign rd_en[c]   = issue && (int'(card_q) == c);
    assign rd_addr[c] = cur_addr;
  end

  assign byte_lo = lo_q;
  assign byte_hi = hi_q;

endmodule

// File: rtl/spi_card_resp.sv
// SPI target answering fixed four-byte card ID EEPROM read frames.
module spi_card_resp
  import spi_card_resp_pkg::*;
#(
  parameter int SEL_W         = 8,
  parameter int SEL_BIT_CARD0 = 5,
  parameter int SEL_BIT_CARD1 = 3,
  parameter int ADDR_W        = 7,
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_BYTES   = 4,
  parameter int OFFSET_BYTE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [SEL_W-1:0]  card_sel,
  input  logic              card0_present,
  input  logic              card1_present,
  output logic              card0_rd_en,
  output logic [ADDR_W-1:0] card0_rd_addr,
  input  logic [7:0]        card0_rd_data,
  output logic              card1_rd_en,
  output logic [ADDR_W-1:0] card1_rd_addr,
  input  logic [7:0]        card1_rd_data
);

  localparam int IDX_W      = $clog2(FRAME_BYTES + 1);
  localparam int DATA_FIRST = FRAME_BYTES - 2;

  logic             rst_n_int;
  logic             sck_s, cs_n_s, mosi_s;
  logic             sck_prev_q, cs_prev_q;
  logic             sck_rise, sck_fall, cs_act, frame_start;
  src_e             pick, mode_q, mode_d;
  logic             out_q, out_d;
  logic [2:0]       bit_idx;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       rx_byte;
  logic             offset_stb;
  logic [7:0]       data_lo, data_hi;
  logic [7:0]       reply_byte;
  logic [1:0]            rd_en_v;
  logic [1:0][ADDR_W-1:0] rd_addr_v;
  logic [1:0][7:0]        rd_data_v;
  logic             unused_bits;

  // Reset release aligned to the clock.
  spi_pin_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (1'b1),
    .d_sync  (rst_n_int)
  );

  // SPI pins into the clock domain: {sck, cs_n, mosi}, idle value 0,1,0.
  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async ({spi_sck, spi_cs_n, spi_mosi}),
    .d_sync  ({sck_s, cs_n_s, mosi_s})
  );

  assign sck_rise    = sck_s & ~sck_prev_q;
  assign sck_fall    = ~sck_s & sck_prev_q;
  assign cs_act      = ~cs_n_s;
  assign frame_start = cs_act & ~cs_prev_q;
  assign pick        = pick_src(card_sel[SEL_BIT_CARD0], card_sel[SEL_BIT_CARD1],
                                card0_present, card1_present);

  spi_frame_seq #(.FRAME_BYTES(FRAME_BYTES), .OFFSET_BYTE(OFFSET_BYTE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .mosi_bit   (mosi_s),
    .bit_idx    (bit_idx),
    .byte_idx   (byte_idx),
    .rx_byte    (rx_byte),
    .offset_stb (offset_stb)
  );

  assign rd_data_v = {card1_rd_data, card0_rd_data};

  spi_card_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (offset_stb),
    .src     (mode_q),
    .base    (rx_byte[ADDR_W-1:0]),
    .rd_en   (rd_en_v),
    .rd_addr (rd_addr_v),
    .rd_data (rd_data_v),
    .byte_lo (data_lo),
    .byte_hi (data_hi)
  );

  assign card0_rd_en   = rd_en_v[0];
  assign card0_rd_addr = rd_addr_v[0];
  assign card1_rd_en   = rd_en_v[1];
  assign card1_rd_addr = rd_addr_v[1];

  // Byte to be shifted out at the current frame position.
  always_comb begin
    reply_byte = BLANK_BYTE;
    if (mode_q != SRC_NONE) begin
      if (byte_idx == IDX_W'(DATA_FIRST))          reply_byte = data_lo;
      else if (byte_idx == IDX_W'(DATA_FIRST + 1)) reply_byte = data_hi;
      else if (byte_idx < IDX_W'(DATA_FIRST))      reply_byte = PAD_BYTE;
    end
  end

  always_comb begin
    out_d  = out_q;
    mode_d = mode_q;
    if (!cs_act) begin
      out_d = 1'b1;
    end else if (frame_start) begin
      mode_d = pick;
      out_d  = (pick == SRC_NONE);
    end else if (sck_fall) begin
      out_d = reply_byte[3'd7 - bit_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b0;
      mode_q     <= SRC_NONE;
      out_q      <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_act;
      mode_q     <= mode_d;
      out_q      <= out_d;
    end
  end

  assign spi_miso    = spi_cs_n | out_q;
  assign unused_bits = ^{card_sel, rx_byte};

endmodule

// File: rtl/spi_card_resp_chk.sv
module spi_card_resp_chk
  import spi_card_resp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              card0_rd_en,
  input logic              card1_rd_en,
  input logic [ADDR_W-1:0] card0_rd_addr,
  input logic [ADDR_W-1:0] card1_rd_addr,
  input src_e              mode_q,
  input logic              cs_act
);

  assert_miso_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_miso)
    else $error("R2 miso low while deselected");

  assert_one_card_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(card0_rd_en && card1_rd_en))
    else $error("R8 both cards read at once");

  assert_owner0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card0_rd_en |-> (mode_q == SRC_CARD0))
    else $error("R5 card 0 read without being the frame source");

  assert_owner1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card1_rd_en |-> (mode_q == SRC_CARD1))
    else $error("R5 card 1 read without being the frame source");

  assert_addr_step0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (card0_rd_en && $past(card0_rd_en)) |-> (card0_rd_addr == $past(card0_rd_addr) + ADDR_W'(1)))
    else $error("R7 card 0 second address not next modulo size");

  assert_addr_step1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (card1_rd_en && $past(card1_rd_en)) |-> (card1_rd_addr == $past(card1_rd_addr) + ADDR_W'(1)))
    else $error("R7 card 1 second address not next modulo size");

  assert_pair_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card0_rd_en) |=> card0_rd_en)
    else $error("R8 card 0 read not paired");

  assert_pair_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (card0_rd_en && $past(card0_rd_en)) |=> !card0_rd_en)
    else $error("R8 card 0 more than two reads");

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |=> $stable(mode_q))
    else $error("R4 frame source changed inside a frame");

endmodule

bind spi_card_resp spi_card_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_cs_n      (spi_cs_n),
  .spi_miso      (spi_miso),
  .card0_rd_en   (card0_rd_en),
  .card1_rd_en   (card1_rd_en),
  .card0_rd_addr (card0_rd_addr),
  .card1_rd_addr (card1_rd_addr),
  .mode_q        (mode_q),
  .cs_act        (cs_act)
);

// File: tb/spi_card_resp_test.sv
`timescale 1ns/1ps
module spi_card_resp_test;

  localparam int HALF     = 80;      // SCK half period, 8 system clocks
  localparam int WATCHDOG = 1000000; // ns

  logic       clk;
  logic       rst_n;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso;
  logic [7:0] card_sel;
  logic       card0_present, card1_present;
  logic       card0_rd_en, card1_rd_en;
  logic [6:0] card0_rd_addr, card1_rd_addr;
  logic [7:0] card0_rd_data, card1_rd_data;

  int n_checks = 0;
  int n_errors = 0;
  int rd_cnt0  = 0;
  int rd_cnt1  = 0;
  bit done     = 0;

  logic [7:0] mem0 [128];
  logic [7:0] mem1 [128];

  spi_card_resp uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sck       (spi_sck),
    .spi_cs_n      (spi_cs_n),
    .spi_mosi      (spi_mosi),
    .spi_miso      (spi_miso),
    .card_sel      (card_sel),
    .card0_present (card0_present),
    .card1_present (card1_present),
    .card0_rd_en   (card0_rd_en),
    .card0_rd_addr (card0_rd_addr),
    .card0_rd_data (card0_rd_data),
    .card1_rd_en   (card1_rd_en),
    .card1_rd_addr (card1_rd_addr),
    .card1_rd_data (card1_rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Card storage models with one-cycle read latency.
  always @(posedge clk) begin
    if (card0_rd_en) card0_rd_data <= mem0[card0_rd_addr];
    if (card1_rd_en) card1_rd_data <= mem1[card1_rd_addr];
    if (card0_rd_en) rd_cnt0 <= rd_cnt0 + 1;
    if (card1_rd_en) rd_cnt1 <= rd_cnt1 + 1;
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] expect_reply(input logic [7:0] sel, input logic p0,
                                               input logic p1, input logic [7:0] off);
    logic [6:0] a, b;
    a = off[6:0];
    b = a + 7'd1;
    if (sel[5]) return p0 ? {16'h0000, mem0[a], mem0[b]} : 32'hFFFF_FFFF;
    if (sel[3]) return p1 ? {16'h0000, mem1[a], mem1[b]} : 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // One frame: nbits clocks, optional card_sel change after bit swap_at.
  task automatic run_frame(input logic [7:0] op, input logic [7:0] off, input int nbits,
                           input int swap_at, input logic [7:0] swap_sel,
                           output logic [31:0] rx);
    logic [31:0] tx;
    logic [31:0] sh;
    tx = {op, off, 16'h0000};
    sh = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[31-i];
      if (i == swap_at) card_sel = swap_sel;
      #(HALF);
      sh = {sh[30:0], spi_miso};
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
    #(HALF);
    spi_cs_n = 1'b1;
    #(2*HALF);
    rx = sh;
  endtask

  task automatic read_case(input string tag, input logic [7:0] sel, input logic p0,
                           input logic p1, input logic [7:0] op, input logic [7:0] off);
    logic [31:0] rx;
    int c0, c1;
    logic valid;
    card_sel = sel; card0_present = p0; card1_present = p1;
    c0 = rd_cnt0; c1 = rd_cnt1;
    run_frame(op, off, 32, -1, sel, rx);
    chk({tag, " reply"}, rx, expect_reply(sel, p0, p1, off));
    valid = (sel[5] && p0) || (!sel[5] && sel[3] && p1);
    // R8: two reads to the addressed card only; R5: none when invalid
    chk({tag, " R8 card0 reads"}, rd_cnt0 - c0, (valid && sel[5]) ? 2 : 0);
    chk({tag, " R8 card1 reads"}, rd_cnt1 - c1, (valid && !sel[5]) ? 2 : 0);
    chk({tag, " R2 idle miso"}, {31'd0, spi_miso}, 32'd1);
  endtask

  task automatic test_reset;
    chk("R2 miso after reset", {31'd0, spi_miso}, 32'd1);
    chk("R8 no reads after reset", {30'd0, card1_rd_en, card0_rd_en}, 32'd0);
  endtask

  task automatic test_card0;
    read_case("R1 R6 card0 off 0x10", 8'h20, 1'b1, 1'b1, 8'h03, 8'h10);
  endtask

  task automatic test_card1;
    read_case("R6 card1 off 0x45", 8'h08, 1'b1, 1'b1, 8'h03, 8'h45);
  endtask

  task automatic test_priority;
    read_case("R4 both bits pick card0", 8'h28, 1'b1, 1'b1, 8'h03, 8'h33);
  endtask

  task automatic test_no_select;
    read_case("R5 no select bit", 8'hD7, 1'b1, 1'b1, 8'h03, 8'h05);
  endtask

  task automatic test_absent;
    read_case("R5 card0 absent", 8'h20, 1'b0, 1'b1, 8'h03, 8'h05);
    read_case("R5 card1 absent", 8'h08, 1'b1, 1'b0, 8'h03, 8'h05);
  endtask

  task automatic test_wrap;
    read_case("R7 wrap 0x7F", 8'h20, 1'b1, 1'b1, 8'h03, 8'h7F);
    read_case("R7 bit7 ignored 0xC3", 8'h08, 1'b1, 1'b1, 8'h03, 8'hC3);
    read_case("R7 0xFF wraps", 8'h20, 1'b1, 1'b1, 8'h03, 8'hFF);
  endtask

  task automatic test_opcode;
    read_case("R3 opcode 0xA5 ignored", 8'h08, 1'b1, 1'b1, 8'hA5, 8'h22);
  endtask

  task automatic test_sel_latched;
    logic [31:0] rx;
    card_sel = 8'h20; card0_present = 1'b1; card1_present = 1'b1;
    run_frame(8'h03, 8'h50, 32, 4, 8'h08, rx);
    chk("R4 select sampled at frame start", rx, expect_reply(8'h20, 1'b1, 1'b1, 8'h50));
  endtask

  task automatic test_abort;
    logic [31:0] rx;
    card_sel = 8'h20; card0_present = 1'b1; card1_present = 1'b1;
    run_frame(8'h03, 8'h11, 12, -1, 8'h20, rx);
    chk("R9 R2 miso high after abort", {31'd0, spi_miso}, 32'd1);
    read_case("R9 frame after abort", 8'h20, 1'b1, 1'b1, 8'h03, 8'h30);
  endtask

  initial begin
    #(WATCHDOG);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem0[i] = 8'((i * 7 + 3) & 8'hFF);
      mem1[i] = 8'(i) ^ 8'hC6;
    end
    rst_n = 1'b0;
    spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    card_sel = 8'h00; card0_present = 1'b0; card1_present = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    test_card0();
    test_card1();
    test_priority();
    test_no_select();
    test_absent();
    test_wrap();
    test_opcode();
    test_sel_latched();
    test_abort();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule